// File: doc/BRIEF.md
# Posted Write Queue with Threshold Admission

This block buffers posted write data, one dword per entry, for one direction of a bridge's bus target port. At the start of each write transaction the bus side raises a request. The block answers in the same cycle with either accept or retry. The answer depends on how much free space the queue has compared with a threshold taken from the current cache line size. A one-bit setting selects between a full cache line and half a cache line. The queue therefore turns writes away while it still has some room. It does not wait until every entry is taken.

Once a transaction is accepted, its data beats flow into the queue until the last beat arrives. If a beat meets a queue that is physically full, the block signals a disconnect, drops that beat and ends the transaction. A drain port on the far side pops dwords in arrival order. A bridge places one instance in each direction, and each instance has its own threshold setting.

Top module: `pwq_admit`

## Requirements
- R1: After reset the queue is empty: free space equals DEPTH, the pop port shows no data, no transaction is open, and the threshold setting is 0.
- R2: With the threshold setting at 0, a request while no transaction is open gets retry if free space is less than the cache line size in dwords. Otherwise it gets accept.
- R3: With the threshold setting at 1 and a cache line size of 8, 16 or 32 dwords, the retry limit is half the cache line size.
- R4: With the threshold setting at 1 and any other cache line size, the retry limit stays at the full cache line size.
- R5: Accept and retry are never high together. Neither is raised for a request made while a transaction is already open. An accept opens a transaction from the next cycle.
- R6: Within an open transaction, every beat is stored while the queue has space. The full threshold is not checked again. A beat that meets a physically full queue raises disconnect in the same cycle, is not stored, and closes the transaction. A beat flagged last also closes it.
- R7: Dwords leave the pop port in the order they were stored.
- R8: Free space always equals DEPTH minus occupancy. It updates on the clock edge after a push or a pop, and a push and a pop in the same cycle leave it unchanged.
- R9: Data beats offered while no transaction is open are ignored and do not change free space.
- R10: The threshold setting loads from its input on a write strobe and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Write strobe for the threshold setting |
| thr_half_in | input | 1 | New threshold setting: 1 selects half a line |
| cls_dw | input | CLS_W | Cache line size in dwords |
| req_start | input | 1 | Start of a posted write transaction |
| accept | output | 1 | Request admitted (combinational) |
| retry | output | 1 | Request refused (combinational) |
| push_valid | input | 1 | Data beat offered |
| push_last | input | 1 | Offered beat ends the transaction |
| push_data | input | DW | Beat data |
| disconnect | output | 1 | Beat refused because the queue is physically full |
| pop_ready | input | 1 | Drain side takes a dword |
| pop_valid | output | 1 | A dword is available |
| pop_data | output | DW | Oldest stored dword |
| free_dw | output | $clog2(DEPTH)+1 | Free entries |

## Verification
The bench sets free space to values that fall between the half-line and full-line limits. At those values, a design that ignored the setting, inverted it, or skipped the fallback for a 12-dword line would give the wrong accept or retry answer. It fills the queue inside an accepted transaction past the admission limit and all the way to physically full. A design that checked the threshold on every beat would stop storing early, and one without the physical check would overwrite unread data. It also offers beats and requests at times they must be ignored, and pushes and pops in the same cycle. A wrong occupancy update or a stray write would show up as a bad free count or as out-of-order data at the drain.

// File: rtl/pwq_admit.sv
module pwq_admit #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int CLS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_we,
  input  logic             thr_half_in,
  input  logic [CLS_W-1:0] cls_dw,
  input  logic             req_start,
  output logic             accept,
  output logic             retry,
  input  logic             push_valid,
  input  logic             push_last,
  input  logic [DW-1:0]    push_data,
  output logic             disconnect,
  input  logic             pop_ready,
  output logic             pop_valid,
  output logic [DW-1:0]    pop_data,
  output logic [$clog2(DEPTH):0] free_dw
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int MW = (CW > CLS_W) ? CW : CLS_W;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    occ;
  logic             half_q;
  logic             busy;
  logic             cls_halvable;
  logic [CLS_W-1:0] need;
  logic             thr_full, phys_full, idle_req;
  logic             push_fire, pop_fire;

  assign cls_halvable = (cls_dw == CLS_W'(8)) || (cls_dw == CLS_W'(16)) || (cls_dw == CLS_W'(32));
  assign need         = (half_q && cls_halvable) ? (cls_dw >> 1) : cls_dw;
  assign free_dw      = CW'(DEPTH) - occ;
  assign thr_full     = MW'(free_dw) < MW'(need);
  assign phys_full    = (occ == CW'(DEPTH));

  assign idle_req   = req_start && !busy;
  assign accept     = idle_req && !thr_full;
  assign retry      = idle_req && thr_full;
  assign push_fire  = busy && push_valid && !phys_full;
  assign disconnect = busy && push_valid && phys_full;

  assign pop_valid = (occ != '0);
  assign pop_fire  = pop_ready && pop_valid;
  assign pop_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) half_q <= 1'b0;
    else if (thr_we) half_q <= thr_half_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else if (accept) busy <= 1'b1;
    else if (disconnect || (push_fire && push_last)) busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_fire) wr_ptr <= wr_ptr + 1'b1;
      if (pop_fire)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_fire, pop_fire})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n) !(accept && retry));
  a_r5_open: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy);
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) occ <= CW'(DEPTH));
  a_r6_disc_closes: assert property (@(posedge clk) disable iff (!rst_n) disconnect |=> !busy);
  a_r2_retry_limit: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> (MW'(free_dw) < MW'(cls_dw)));
  a_r8_free_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && busy && pop_ready && pop_valid && !phys_full) |=> $stable(free_dw));
endmodule

// File: tb/pwq_admit_tb.sv
module pwq_admit_tb;
  localparam int DEPTH = 64;
  localparam int DW = 32;
  localparam int CLS_W = 8;

  logic clk = 0, rst_n = 0;
  logic thr_we = 0, thr_half_in = 0;
  logic [CLS_W-1:0] cls_dw = 8'd16;
  logic req_start = 0, push_valid = 0, push_last = 0, pop_ready = 0;
  logic [DW-1:0] push_data = '0;
  logic accept, retry, disconnect, pop_valid;
  logic [DW-1:0] pop_data;
  logic [$clog2(DEPTH):0] free_dw;

  int checks = 0, failures = 0, exp_free = DEPTH;
  logic [DW-1:0] sb[$];
  logic [DW-1:0] seq = 32'hA000_0000;
  bit exp_open = 0;

  always #5ns clk = ~clk;

  pwq_admit #(.DEPTH(DEPTH), .DW(DW), .CLS_W(CLS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_half_in(thr_half_in), .cls_dw(cls_dw),
    .req_start(req_start), .accept(accept), .retry(retry), .push_valid(push_valid),
    .push_last(push_last), .push_data(push_data), .disconnect(disconnect),
    .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data), .free_dw(free_dw));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare each popped dword with the scoreboard (R7)
  always @(posedge clk) begin
    if (rst_n && pop_valid && pop_ready) begin
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL R7 actual=%0h expected=<empty>", pop_data);
      end else begin
        logic [DW-1:0] e;
        e = sb.pop_front();
        if (pop_data !== e) begin
          failures++;
          $display("FAIL R7 actual=%0h expected=%0h", pop_data, e);
        end
      end
    end
  end

  // all tasks begin and end at a falling edge
  task automatic request(string req, bit exp_acc, bit exp_rty);
    req_start = 1;
    #1;
    chk({req, " accept"}, accept, exp_acc);
    chk({req, " retry"}, retry, exp_rty);
    if (exp_acc) exp_open = 1;
    @(negedge clk);
    req_start = 0;
  endtask

  task automatic beats(int n, bit end_last, bit with_pop, string req);
    for (int i = 0; i < n; i++) begin
      push_valid = 1;
      push_last = end_last && (i == n - 1);
      push_data = seq;
      pop_ready = with_pop;
      #1;
      if (exp_open) begin
        chk({req, " disconnect"}, disconnect, (exp_free == 0) ? 1 : 0);
        if (exp_free == 0) exp_open = 0;
        else begin
          sb.push_back(seq);
          if (!with_pop) exp_free--;
          if (push_last) exp_open = 0;
        end
      end else chk({req, " disconnect idle"}, disconnect, 0);
      seq++;
      @(negedge clk);
      push_valid = 0;
      push_last = 0;
      pop_ready = 0;
    end
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      pop_ready = 1;
      @(negedge clk);
      exp_free++;
    end
    pop_ready = 0;
  endtask

  task automatic set_thr(bit v);
    thr_we = 1;
    thr_half_in = v;
    @(negedge clk);
    thr_we = 0;
    thr_half_in = ~v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 free", free_dw, DEPTH);
    chk("R1 pop_valid", pop_valid, 0);
    beats(2, 1, 0, "R9");
    chk("R9 free after idle beats", free_dw, DEPTH);

    request("R2 empty", 1, 0);
    request("R5 request while open", 0, 0);
    beats(50, 1, 0, "R6");
    chk("R8 free after 50", free_dw, exp_free);
    request("R1 R2 free 14 < line 16 at reset setting", 0, 1);

    set_thr(1);
    request("R3 free 14 >= half 8", 1, 0);
    beats(7, 1, 0, "R6");
    chk("R8 free 7", free_dw, 7);
    request("R3 free 7 < half 8", 0, 1);

    cls_dw = 8'd12;
    request("R4 cls 12 no halving", 0, 1);

    cls_dw = 8'd8;
    request("R3 free 7 >= half 4", 1, 0);
    beats(10, 0, 0, "R6 fill past limit");
    chk("R6 free 0", free_dw, 0);
    request("R5 transaction closed by disconnect", 0, 1);
    beats(1, 0, 0, "R9");
    chk("R9 free stays 0", free_dw, 0);

    set_thr(0);
    drain(5);
    chk("R8 free 5", free_dw, 5);
    request("R10 setting 0 loaded: 5 < 8", 0, 1);

    drain(5);
    request("R2 free 10 >= 8", 1, 0);
    beats(3, 0, 1, "R8 push and pop");
    chk("R8 free unchanged", free_dw, 10);
    beats(1, 1, 0, "R6 last");
    chk("R8 free 9", free_dw, 9);

    drain(DEPTH - 9);
    chk("R8 drained free", free_dw, DEPTH);
    chk("R7 scoreboard empty", sb.size(), 0);
    chk("R7 pop_valid low", pop_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200us;
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule